// File: doc/BRIEF.md
# Partial-Word Store Byte-Lane Unit

This unit converts a "store bytes" request into exactly one write beat on a big-endian, doubleword-wide data memory port. A request carries a byte address, a register value, a mode bit (begin or end form) and a size bit (word or doubleword). The unit works out which bytes of the addressed word or doubleword are touched, moves the value's bytes onto those lanes, and sends one masked write toward memory. A partial store of 3, 5, 6 or 7 bytes therefore reaches memory as a single indivisible beat.

The begin form writes from the addressed byte up to the end of the aligned unit, using the low-order bytes of the value. The end form writes from the start of the unit up to, but not including, the addressed byte, using the high-order bytes of the value. An end-form request at offset zero writes no byte. It still produces a beat with a zero-length flag, so that downstream logic can run its write-permission check and mark the line dirty.

Both sides use valid/ready handshakes. A single registered output stage holds each beat until memory accepts it. That stage takes a new request in the same cycle the previous beat leaves.

Top module: `psb_lane_unit`

## Requirements
- R1: After reset, `mem_valid` is 0 and `req_ready` is 1.
- R2: Lane j (`mem_be[j]`, `mem_wdata[63-8j:56-8j]`) holds the byte at address `mem_addr + j`, and `mem_addr` is `req_addr` with bits [2:0] cleared. With `req_dword`=1, k = `req_addr[2:0]` and the unit is lanes 0..7. With `req_dword`=0, k = `req_addr[1:0]` and the unit is lanes 0..3 if `req_addr[2]`=0, or lanes 4..7 if it is 1. Unit index i of the value is byte (unit size − 1 − i) of the value, counted from the least-significant byte. In other words, the value is placed big-endian in its unit.
- R3: Begin form (`req_end`=0) with offset k enables unit indices k through the end of the unit. These lanes receive the least-significant (unit size − k) bytes of the value.
- R4: Begin form with offset 0 enables the whole unit, and the whole unit-sized value is written.
- R5: End form (`req_end`=1) with offset k>0 enables unit indices 0 through k−1. These lanes receive the most-significant k bytes of the value.
- R6: End form with offset 0 gives `mem_be`=0 and `mem_probe`=1. Every other request gives `mem_probe`=0 and at least one enabled lane.
- R7: In word mode only the low 32 bits of `req_data` are used, and all data lanes outside the selected half are 0.
- R8: Each accepted request yields exactly one beat, and the enabled lanes of that beat form one contiguous run.
- R9: While `mem_valid`=1 and `mem_ready`=0, the beat stays unchanged and `req_ready` is 0, so no new request is taken.
- R10: When `mem_ready` is held at 1, a request is accepted on every cycle. Its beat appears on the cycle after acceptance, and `mem_valid` drops once no request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 32 | Byte address |
| req_data | input | 64 | Register value |
| req_end | input | 1 | 0 = begin form, 1 = end form |
| req_dword | input | 1 | 0 = word unit, 1 = doubleword unit |
| mem_valid | output | 1 | Write beat present |
| mem_ready | input | 1 | Memory takes the beat on this edge |
| mem_addr | output | 32 | Doubleword-aligned address |
| mem_be | output | 8 | Lane enables, bit j = address mem_addr+j |
| mem_wdata | output | 64 | Lane-positioned data, lane 0 in bits 63:56 |
| mem_probe | output | 1 | Zero-length access: check permission, mark dirty |

## Verification
Two things can happen in the same cycle: the previous beat is taken by memory, and a new request is accepted into the output stage. The bench provokes this by holding `req_valid` across consecutive cycles with `mem_ready` high. It also provokes it by releasing a stall while a second request is already waiting. It then judges each following cycle's beat against the request expected in that slot. A reference byte memory, updated from each beat and compared with contents computed from the rules, catches a lost, duplicated or misplaced beat.

// File: rtl/psb_pkg.sv
package psb_pkg;
  typedef enum logic {
    FORM_BEGIN = 1'b0,
    FORM_END   = 1'b1
  } form_e;
endpackage

// File: rtl/psb_mask.sv
module psb_mask #(
  parameter int NB = 8
) (
  input  logic [$clog2(NB)-1:0] off,
  input  psb_pkg::form_e        form,
  input  logic                  dword,
  output logic [NB-1:0]         lane_en,
  output logic                  zero_len
);
  localparam int OFF_W = $clog2(NB);
  localparam int HALF  = NB / 2;
  localparam int HW    = $clog2(HALF);

  logic [OFF_W:0] kd_x;
  logic [OFF_W:0] kw_x;
  logic           half_sel;
  logic           is_end;

  assign is_end   = (form == psb_pkg::FORM_END);
  assign kd_x     = {1'b0, off};
  assign kw_x     = {{(OFF_W+1-HW){1'b0}}, off[HW-1:0]};
  assign half_sel = off[HW];

  for (genvar j = 0; j < NB; j++) begin : g_lane
    localparam logic [OFF_W:0] JD = (OFF_W+1)'(j);
    localparam logic [OFF_W:0] JW = (OFF_W+1)'(j % HALF);
    localparam logic           HJ = (j >= HALF);
    logic dsel, wsel;
    assign dsel = is_end ? (JD < kd_x) : (JD >= kd_x);
    assign wsel = (half_sel == HJ) && (is_end ? (JW < kw_x) : (JW >= kw_x));
    assign lane_en[j] = dword ? dsel : wsel;
  end

  assign zero_len = is_end && (dword ? (off == '0) : (off[HW-1:0] == '0));

  // R7: a word-sized store never spans both halves
  always_comb begin
    if (!dword) begin
      a_r7_one_half : assert (!((|lane_en[HALF-1:0]) && (|lane_en[NB-1:HALF])));
    end
  end
endmodule

// File: rtl/psb_place.sv
module psb_place #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] value,
  input  logic              dword,
  input  logic              half_sel,
  output logic [DATA_W-1:0] placed
);
  localparam int HB = DATA_W / 2;

  always_comb begin
    if (dword) begin
      placed = value;
    end else if (half_sel) begin
      placed = {{HB{1'b0}}, value[HB-1:0]};
    end else begin
      placed = {value[HB-1:0], {HB{1'b0}}};
    end
  end
endmodule

// File: rtl/psb_oreg.sv
module psb_oreg #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_payload,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_payload
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_payload <= '0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_payload <= in_payload;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

  // R9: a stalled beat stays put
  a_r9_hold : assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_payload));

  // R10: an accepted request shows up on the next cycle
  a_r10_accept : assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R8: a retired beat with nothing behind it is not repeated
  a_r8_single : assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: rtl/psb_lane_unit.sv
module psb_lane_unit #(
  parameter int AW     = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_end,
  input  logic              req_dword,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_probe
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);
  localparam int PW    = AW + NB + DATA_W + 1;

  psb_pkg::form_e    form;
  logic [NB-1:0]     lane_en;
  logic              zero_len;
  logic [DATA_W-1:0] placed;
  logic [AW-1:0]     base;
  logic [PW-1:0]     pay_in, pay_out;

  assign form = req_end ? psb_pkg::FORM_END : psb_pkg::FORM_BEGIN;
  assign base = {req_addr[AW-1:OFF_W], {OFF_W{1'b0}}};

  psb_mask #(.NB(NB)) u_mask (
    .off      (req_addr[OFF_W-1:0]),
    .form     (form),
    .dword    (req_dword),
    .lane_en  (lane_en),
    .zero_len (zero_len)
  );

  psb_place #(.DATA_W(DATA_W)) u_place (
    .value    (req_data),
    .dword    (req_dword),
    .half_sel (req_addr[OFF_W-1]),
    .placed   (placed)
  );

  assign pay_in = {base, lane_en, placed, zero_len};

  psb_oreg #(.PW(PW)) u_oreg (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (req_valid),
    .in_ready    (req_ready),
    .in_payload  (pay_in),
    .out_valid   (mem_valid),
    .out_ready   (mem_ready),
    .out_payload (pay_out)
  );

  assign {mem_addr, mem_be, mem_wdata, mem_probe} = pay_out;

  // R6: zero-length beat carries no enabled lane
  a_r6_probe_empty : assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_probe |-> mem_be == '0);

  // R6: every other beat writes something
  a_r6_write_nonempty : assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_probe |-> mem_be != '0);

  // R8: enabled lanes form one run
  a_r8_one_run : assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_probe |->
      $countones({1'b0, mem_be, 1'b0} ^ ({1'b0, mem_be, 1'b0} >> 1)) == 2);
endmodule

// File: tb/psb_lane_unit_bench.sv
module psb_lane_unit_bench;
  localparam int CLK_NS = 10;
  localparam logic [31:0] BASE = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [63:0] req_data = '0;
  logic        req_end = 1'b0;
  logic        req_dword = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic        mem_probe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] dut_mem [16];
  logic [7:0] exp_mem [16];

  always #(CLK_NS/2) clk = ~clk;

  psb_lane_unit u_psb_lane_unit (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data),
    .req_end(req_end), .req_dword(req_dword),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_probe(mem_probe)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_be(input logic [31:0] a, input bit e, input bit d);
    int u, k, lo;
    logic [7:0] r = '0;
    u  = d ? 8 : 4;
    k  = int'(a) % u;
    lo = d ? 0 : (a[2] ? 4 : 0);
    for (int j = 0; j < 8; j++) begin
      int i = j - lo;
      if (i >= 0 && i < u) r[j] = e ? (i < k) : (i >= k);
    end
    return r;
  endfunction

  function automatic logic [63:0] exp_data(input logic [31:0] a, input logic [63:0] v, input bit d);
    if (d) return v;
    if (a[2]) return {32'h0, v[31:0]};
    return {v[31:0], 32'h0};
  endfunction

  task automatic model_expected(input logic [31:0] a, input logic [63:0] v, input bit e, input bit d);
    int u, k, ub;
    u  = d ? 8 : 4;
    k  = int'(a) % u;
    ub = int'(a - BASE) - k;
    for (int i = 0; i < u; i++) begin
      if (e ? (i < k) : (i >= k)) exp_mem[ub + i] = v[(u-1-i)*8 +: 8];
    end
  endtask

  task automatic model_dut();
    int off;
    off = int'(mem_addr - BASE);
    for (int j = 0; j < 8; j++) begin
      if (mem_be[j]) dut_mem[off + j] = mem_wdata[63-8*j -: 8];
    end
  endtask

  task automatic compare_mem(input string tag);
    for (int i = 0; i < 16; i++) check(tag, {56'h0, dut_mem[i]}, {56'h0, exp_mem[i]});
  endtask

  // checks one beat on the port at the current negedge
  task automatic check_beat(input logic [31:0] a, input logic [63:0] v, input bit e, input bit d);
    string t;
    bit zl;
    zl = e && ((int'(a) % (d ? 8 : 4)) == 0);
    t = $sformatf("a=%h end=%0d dw=%0d", a, e, d);
    check({"R10 valid ", t}, {63'h0, mem_valid}, 64'h1);
    check({"R2 addr ", t}, {32'h0, mem_addr}, {32'h0, a[31:3], 3'b000});
    check({e ? (zl ? "R6 be " : "R5 be ") : "R3 be ", t}, {56'h0, mem_be}, {56'h0, exp_be(a, e, d)});
    check({"R6 probe ", t}, {63'h0, mem_probe}, {63'h0, zl});
    check({d ? "R4 data " : "R7 data ", t}, mem_wdata, exp_data(a, v, d));
    model_dut();
    model_expected(a, v, e, d);
  endtask

  task automatic do_store(input logic [31:0] a, input logic [63:0] v, input bit e, input bit d);
    req_valid = 1'b1; req_addr = a; req_data = v; req_end = e; req_dword = d;
    mem_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check_beat(a, v, e, d);
  endtask

  task automatic t_reset();
    check("R1 mem_valid after reset", {63'h0, mem_valid}, 64'h0);
    check("R1 req_ready after reset", {63'h0, req_ready}, 64'h1);
  endtask

  task automatic t_sweep();
    for (int d = 0; d < 2; d++) begin
      for (int e = 0; e < 2; e++) begin
        for (int k = 0; k < 8; k++) begin
          logic [63:0] v = 64'h1122334455667788 ^ {8{8'(k*17 + e*5 + d*3)}};
          do_store(BASE + 32'(k) + 32'(8*e), v, bit'(e), bit'(d));
        end
      end
    end
    @(posedge clk); @(negedge clk);
    check("R10 idle after sweep", {63'h0, mem_valid}, 64'h0);
    compare_mem("R2 memory after sweep");
  endtask

  task automatic t_stall();
    logic [63:0] v1 = 64'hA1A2A3A4A5A6A7A8;
    logic [63:0] v2 = 64'hB1B2B3B4B5B6B7B8;
    logic [7:0] be0;
    logic [63:0] wd0;
    mem_ready = 1'b0;
    req_valid = 1'b1; req_addr = BASE + 32'd3; req_data = v1; req_end = 1'b0; req_dword = 1'b1;
    @(posedge clk); @(negedge clk);
    be0 = mem_be; wd0 = mem_wdata;
    req_addr = BASE + 32'd13; req_data = v2; req_end = 1'b1; req_dword = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk);
      check("R9 stalled valid", {63'h0, mem_valid}, 64'h1);
      check("R9 ready low in stall", {63'h0, req_ready}, 64'h0);
      check("R9 be held", {56'h0, mem_be}, {56'h0, be0});
      check("R9 data held", mem_wdata, wd0);
    end
    check_beat(BASE + 32'd3, v1, 1'b0, 1'b1);
    mem_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check_beat(BASE + 32'd13, v2, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R8 no repeat after stall", {63'h0, mem_valid}, 64'h0);
    compare_mem("R8 memory after stall");
  endtask

  task automatic t_back_to_back();
    logic [31:0] aa [3];
    logic [63:0] vv [3];
    bit ee [3];
    bit dd [3];
    aa[0] = BASE + 32'd1;  vv[0] = 64'hC0C1C2C3C4C5C6C7; ee[0] = 1'b1; dd[0] = 1'b1;
    aa[1] = BASE + 32'd8;  vv[1] = 64'hD0D1D2D3D4D5D6D7; ee[1] = 1'b1; dd[1] = 1'b1;
    aa[2] = BASE + 32'd6;  vv[2] = 64'hE0E1E2E3E4E5E6E7; ee[2] = 1'b0; dd[2] = 1'b0;
    mem_ready = 1'b1;
    for (int n = 0; n < 3; n++) begin
      req_valid = 1'b1; req_addr = aa[n]; req_data = vv[n]; req_end = ee[n]; req_dword = dd[n];
      @(posedge clk); @(negedge clk);
      if (n == 2) req_valid = 1'b0;
      check("R10 ready each cycle", {63'h0, req_ready}, 64'h1);
      check_beat(aa[n], vv[n], ee[n], dd[n]);
    end
    @(posedge clk); @(negedge clk);
    check("R10 valid drops", {63'h0, mem_valid}, 64'h0);
    compare_mem("R8 memory after burst");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      dut_mem[i] = 8'hEE;
      exp_mem[i] = 8'hEE;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sweep();
    t_stall();
    t_back_to_back();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule